// File: doc/BRIEF.md
# Quad Core Wakeup Request Register

This block is a slave on a word-addressed 64-bit control bus. It serves a group of four processor cores. Power-management firmware writes a single control word to raise or drop a special-wakeup request. The same write sets a shared completion flag. The block keeps one request bit for each core and drives both the request bits and the completion flag to the power-sequencing logic next to it.

Cores are chosen by a four-bit nibble in the word address, not by the data. The decoder removes that nibble before it compares offsets, and then uses the nibble as a per-core write enable. One write can therefore update any subset of the four cores. Data and address bits in the requirements are numbered MSB-first, as software sees them: data bit 0 is `req_wdata[63]`, and offset bit k is `req_addr[31-k]`. Software reads the completion flag back through a status word. A read answers with a one-cycle valid pulse.

Top module: `quad_wakeup_ctl`

## Requirements
- R1: After reset, `wake_req` is 0000, `wake_done` is 0 and `rd_valid` is 0.
- R2: `rd_valid` goes high in the cycle after a read strobe and only then. A write never produces `rd_valid`.
- R3: A write whose offset, with the selection nibble removed, equals 0x83c sets `wake_done` to data bit 0 (`req_wdata[63]`).
- R4: On that same write, core i (i = 0..3) takes data bit 0 into `wake_req[i]` when offset bit 16+i (`req_addr[15-i]`) is set. Cores whose bit is clear keep their value.
- R5: Offset bits 16..19 (`req_addr[15:12]`) are ignored when the offset is decoded. Every nibble value reaches the control and status words.
- R6: A read whose masked offset is 0x82c returns zero while `wake_done` is clear. While it is set, the read returns data bits 1 and 4 set (0x4800_0000_0000_0000).
- R7: A read of any other masked offset, including 0x83c, returns all ones.
- R8: A write to any masked offset other than 0x83c changes neither `wake_req` nor `wake_done`.
- R9: A control write with an all-zero selection nibble updates only `wake_done`. A write of data bit 0 = 0 clears the selected request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word offset (byte address >> 3) |
| req_wdata | input | 64 | Write data, MSB-first bit 0 at [63] |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rd_data | output | 64 | Read data |
| wake_req | output | 4 | Per-core wakeup request, bit i for core i |
| wake_done | output | 1 | Shared wakeup completion flag |

## Verification
The control write is tried with single-core nibbles, a sparse two-core nibble, an empty nibble and set and clear data. These cases show whether the nibble-to-core order is right, whether unselected cores keep their bits, and whether the done flag follows the data on its own. Status reads are made with several nibble values while the flag is set and while it is clear. This separates correct masking from an exact-offset compare, and a correct bit position from a shifted one. Reads and writes at neighbouring and unrelated offsets, including back-to-back reads, check the all-ones default, that stray writes are ignored, and that the valid pulse is one cycle long.

// File: rtl/quad_wakeup_pkg.sv
package quad_wakeup_pkg;
  typedef struct packed {
    logic ctl;
    logic sts;
  } qw_hit_t;
endpackage

// File: rtl/qw_addr_decode.sv
module qw_addr_decode
  import quad_wakeup_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CORES   = 4,
  parameter int unsigned SEL_LSB = 12,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h83c,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h82c
) (
  input  logic [ADDR_W-1:0] addr,
  output qw_hit_t           hit,
  output logic [CORES-1:0]  core_sel
);
  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'({CORES{1'b1}}) << SEL_LSB;

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked  = addr & ~SEL_MASK;
    hit.ctl = (masked == CTL_OFS);
    hit.sts = (masked == STS_OFS);
  end

  // MSB-first nibble: the highest address bit of the nibble selects core 0
  for (genvar i = 0; i < CORES; i++) begin : g_sel
    assign core_sel[i] = addr[SEL_LSB + CORES - 1 - i];
  end
endmodule

// File: rtl/qw_wake_state.sv
module qw_wake_state #(
  parameter int unsigned CORES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CORES-1:0] sel,
  input  logic             wbit,
  output logic [CORES-1:0] wake_q,
  output logic             done_q
);
  logic [CORES-1:0] wake_d;
  logic             done_d;

  always_comb begin
    wake_d = wake_q;
    done_d = done_q;
    if (wr_en) begin
      done_d = wbit;
      for (int i = 0; i < CORES; i++) begin
        if (sel[i]) wake_d[i] = wbit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
      done_q <= 1'b0;
    end else if (wr_en) begin
      wake_q <= wake_d;
      done_q <= done_d;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wake_q) && $stable(done_q)));

  assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done_q == $past(wbit)));

  assert_unsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((wake_q & ~$past(sel)) == ($past(wake_q) & ~$past(sel))));

  assert_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((wake_q & $past(sel)) == ({CORES{$past(wbit)}} & $past(sel))));
endmodule

// File: rtl/qw_read_path.sv
module qw_read_path
  import quad_wakeup_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  qw_hit_t           hit,
  input  logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  // status bits 1 and 4 counted MSB-first
  localparam logic [DATA_W-1:0] STS_SET =
    (DATA_W'(1) << (DATA_W - 2)) | (DATA_W'(1) << (DATA_W - 5));

  logic [DATA_W-1:0] data_d;

  always_comb begin
    if (hit.sts) data_d = done ? STS_SET : '0;
    else         data_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= data_d;
  end

  assert_rdv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  assert_nordv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);

  assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !hit.sts) |=> (rd_data == '1));

  assert_stsclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && hit.sts && !done) |=> (rd_data == '0));
endmodule

// File: rtl/quad_wakeup_ctl.sv
module quad_wakeup_ctl
  import quad_wakeup_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CORES  = 4,
  parameter int unsigned SEL_MSB_FIRST = 16,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h83c,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h82c
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CORES-1:0]  wake_req,
  output logic              wake_done
);
  localparam int unsigned SEL_LSB = ADDR_W - SEL_MSB_FIRST - CORES;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  qw_hit_t          hit;
  logic [CORES-1:0] core_sel;
  logic             wr_en;
  logic             rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign wr_en  = req_valid &  req_write & hit.ctl;
  assign rd_stb = req_valid & ~req_write;

  qw_addr_decode #(
    .ADDR_W(ADDR_W), .CORES(CORES), .SEL_LSB(SEL_LSB),
    .CTL_OFS(CTL_OFS), .STS_OFS(STS_OFS)
  ) u_dec (
    .addr(req_addr), .hit(hit), .core_sel(core_sel)
  );

  qw_wake_state #(.CORES(CORES)) u_state (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .sel(core_sel),
    .wbit(req_wdata[DATA_W-1]), .wake_q(wake_req), .done_q(wake_done)
  );

  qw_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .rd_stb(rd_stb), .hit(hit),
    .done(wake_done), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_wrnovalid_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_write) |=> !rd_valid);
endmodule

// File: tb/quad_wakeup_ctl_tb_top.sv
module quad_wakeup_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [3:0]  wake_req;
  logic        wake_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  m_wake;
  logic        m_done;

  localparam logic [63:0] STS_ON = 64'h4800_0000_0000_0000;

  always #2.5 clk = ~clk;

  quad_wakeup_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .wake_req(wake_req), .wake_done(wake_done)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design produces a result
  always @(posedge clk) begin
    #1;
    if (rst_n && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) chk("R2 unexpected rd_valid", 64'd1, 64'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // driver: called at a negedge, holds the access for one edge
  task automatic wr(input logic [31:0] a, input logic [63:0] d, input string r);
    logic [31:0] m;
    m = a & ~32'h0000_f000;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    if (m == 32'h83c) begin
      m_done = d[63];
      for (int i = 0; i < 4; i++) if (a[15-i]) m_wake[i] = d[63];
    end
    @(negedge clk);
    chk({r, " wake_req"}, {60'd0, wake_req}, {60'd0, m_wake});
    chk({r, " wake_done"}, {63'd0, wake_done}, {63'd0, m_done});
  endtask

  task automatic rd(input logic [31:0] a, input string r);
    logic [31:0] m;
    m = a & ~32'h0000_f000;
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = '0;
    if (m == 32'h82c) exp_q.push_back(m_done ? STS_ON : 64'd0);
    else              exp_q.push_back('1);
    tag_q.push_back(r);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0; req_write = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    m_wake = '0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 wake_req", {60'd0, wake_req}, 64'd0);
    chk("R1 wake_done", {63'd0, wake_done}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);

    rd(32'h0000_082c, "R6 status clear");
    idle(1);
    wr(32'h0000_883c, 64'h8000_0000_0000_0000, "R3 R4 core0 set");
    rd(32'h0000_082c, "R6 status set");
    rd(32'h0000_f82c, "R5 status nibble F");
    rd(32'h0000_382c, "R5 status nibble 3");
    idle(1);
    wr(32'h0000_583c, 64'hffff_ffff_ffff_ffff, "R4 R5 cores 1 and 3");
    wr(32'h0000_083c, 64'h7fff_ffff_ffff_ffff, "R9 empty nibble clears done");
    rd(32'h0000_082c, "R6 status after clear");
    wr(32'h0000_483c, 64'h0, "R9 clear core1");
    wr(32'h0000_283c, 64'h8000_0000_0000_0000, "R4 core2 set");
    wr(32'h0000_f840, 64'h0, "R8 other offset");
    wr(32'h0000_f82c, 64'h0, "R8 status offset write");
    wr(32'h0001_f83c, 64'h0, "R8 high address bit");
    rd(32'h0000_1234, "R7 unrelated read");
    rd(32'h0000_083c, "R7 control offset read");
    rd(32'h0000_082d, "R7 neighbour read");
    idle(1);
    wr(32'h0000_f83c, 64'h0, "R9 clear all");
    rd(32'h0000_a82c, "R6 status after clear all");
    idle(3);
    chk("R2 queue drained", 64'(exp_q.size()), 64'd0);
    chk("R2 no stray valid", {63'd0, rd_valid}, 64'd0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule